// File: doc/BRIEF.md
# Two-Channel Serial Interrupt Vectoring

This block produces the single interrupt line of a two-channel serial controller, together with the interrupt-pending byte that the host reads on channel A and the modified vector byte that it reads on channel B. Each channel reports three kinds of event: a received character, a transmit buffer that has emptied after a character was sent, and a break. The host controls the block with per-channel strobes. A data-port read services the receiver, and a data-port write loads the transmitter. Two commands are also available: one resets the pending transmit interrupt and one resets the highest interrupt under service.

Each channel keeps a pending flag and an under-service flag for receive and for transmit. Receive takes precedence over transmit. While a receive interrupt is under service, a transmit interrupt is only remembered: it does not touch the vector or the pending byte until the receive service is released. The vector code takes one of two encodings, picked by a status-high select input.

Top module: `sio_irq_vector`

## Requirements
- R1: `irq` is high in the cycle after any channel requests service. A channel requests service when its transmit-enable bit (`wr1_x[1]`) is set and transmit is pending, or when its receive mode field (`wr1_x[4:3]`) is 01 or 10 and receive is pending, or when `brk_en` is set for it and its break flag is set.
- R2: `pend` bit positions: receive A 0x20, transmit A 0x10, receive B 0x04, transmit B 0x02. The external-status bits 0x08 and 0x01 stay 0.
- R3: With `stat_hi`=0, `vec` codes are: receive A 0x0C, transmit A 0x08, receive B 0x04, transmit B 0x00, none 0x06. With `stat_hi`=1 they are: receive A 0x30, transmit A 0x10, receive B 0x20, transmit B 0x00, none 0x60.
- R4: A receive event sets receive pending and receive under-service, sets the channel's receive bit in `pend`, and writes the receive code to `vec`.
- R5: A transmit event always sets transmit pending. If receive is under service on that channel, `vec` and `pend` are left unchanged. Otherwise it sets transmit under-service, writes the transmit code, and sets the transmit bit of `pend` when transmit interrupts are enabled.
- R6: The reset-highest-IUS command first tries to release receive under-service, and then re-raises a pending transmit interrupt as in R5. If receive is not under service, the command instead clears transmit under-service.
- R7: The reset-TX-pending command clears transmit pending and under-service, clears the transmit bit of `pend` and writes the none code. If receive is still pending, the receive interrupt is then raised again as in R4.
- R8: A data read clears receive pending and under-service, clears the receive bit of `pend` and writes the none code. A pending transmit interrupt is then raised again as in R5.
- R9: A data write clears transmit pending only, so the request drops. A later transmit event raises it again.
- R10: The transmit bit of `pend` is never set while that channel's transmit-enable bit is 0.
- R11: A break event sets a sticky break flag, and only reset clears it.
- R12: When both channels act in the same cycle, channel A is processed first and then channel B, so B's code is the one left in `vec`.
- R13: After reset, `irq`=0, `pend`=0x00 and `vec`=0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr1_a | input | 8 | Channel A interrupt-enable byte |
| wr1_b | input | 8 | Channel B interrupt-enable byte |
| brk_en | input | 2 | Break interrupt enable, bit 0 = A, bit 1 = B |
| stat_hi | input | 1 | Vector encoding select |
| rx_evt | input | 2 | Character received (bit 0 = A) |
| tx_evt | input | 2 | Character sent, buffer empty |
| brk_evt | input | 2 | Break detected |
| rd_data | input | 2 | Host data-port read strobe |
| wr_data | input | 2 | Host data-port write strobe |
| cmd_rst_tx | input | 2 | Reset-TX-pending command strobe |
| cmd_rst_ius | input | 2 | Reset-highest-IUS command strobe |
| irq | output | 1 | Shared interrupt request |
| pend | output | 8 | Interrupt-pending byte |
| vec | output | 8 | Modified vector byte |

## Verification
The assertions assume that each channel receives at most one host strobe (read, write or command) in a cycle. Within a channel the strobes are resolved in the order read, write, TX reset, IUS reset, and the assertions rely on that fixed order. The stimulus always picks a single action per channel per cycle, and it sometimes drives both channels together to exercise the A-then-B order. The configuration inputs are changed only while reset is held.

// File: rtl/sio_irq_vector.sv
module sio_irq_vector #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [7:0]     wr1_a,
  input  logic [7:0]     wr1_b,
  input  logic [NCH-1:0] brk_en,
  input  logic           stat_hi,
  input  logic [NCH-1:0] rx_evt,
  input  logic [NCH-1:0] tx_evt,
  input  logic [NCH-1:0] brk_evt,
  input  logic [NCH-1:0] rd_data,
  input  logic [NCH-1:0] wr_data,
  input  logic [NCH-1:0] cmd_rst_tx,
  input  logic [NCH-1:0] cmd_rst_ius,
  output logic           irq,
  output logic [7:0]     pend,
  output logic [7:0]     vec
);

  function automatic logic [7:0] rx_code(int c, logic hi);
    if (hi) return (c == 0) ? 8'h30 : 8'h20;
    return (c == 0) ? 8'h0C : 8'h04;
  endfunction

  function automatic logic [7:0] tx_code(int c, logic hi);
    if (c != 0) return 8'h00;
    return hi ? 8'h10 : 8'h08;
  endfunction

  function automatic logic [7:0] rx_bit(int c);
    return (c == 0) ? 8'h20 : 8'h04;
  endfunction

  function automatic logic [7:0] tx_bit(int c);
    return (c == 0) ? 8'h10 : 8'h02;
  endfunction

  logic [NCH-1:0][7:0] cfg;
  assign cfg = {wr1_b, wr1_a};

  logic [NCH-1:0] rxp_q, txp_q, rxs_q, txs_q, brk_q;
  logic [NCH-1:0] rxp_d, txp_d, rxs_d, txs_d, brk_d;
  logic [7:0]     pend_q, vec_q, pend_d, vec_d;
  logic           irq_q;
  logic [NCH-1:0] req;
  logic           do_rx, do_tx;
  logic [7:0]     none_code;

  assign none_code = stat_hi ? 8'h60 : 8'h06;

  always_comb begin
    for (int c = 0; c < NCH; c++)
      req[c] = (cfg[c][1] & txp_q[c]) | ((^cfg[c][4:3]) & rxp_q[c]) | (brk_en[c] & brk_q[c]);
  end

  always_comb begin
    rxp_d = rxp_q; txp_d = txp_q; rxs_d = rxs_q; txs_d = txs_q; brk_d = brk_q;
    pend_d = pend_q; vec_d = vec_q;
    do_rx = 1'b0; do_tx = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      do_rx = 1'b0;
      do_tx = 1'b0;
      if (rd_data[c]) begin
        rxp_d[c] = 1'b0;
        rxs_d[c] = 1'b0;
        vec_d    = none_code;
        pend_d   = pend_d & ~rx_bit(c);
        do_tx    = txp_d[c];
      end else if (wr_data[c]) begin
        txp_d[c] = 1'b0;
      end else if (cmd_rst_tx[c]) begin
        txp_d[c] = 1'b0;
        txs_d[c] = 1'b0;
        vec_d    = none_code;
        pend_d   = pend_d & ~tx_bit(c);
        do_rx    = rxp_d[c];
      end else if (cmd_rst_ius[c]) begin
        if (rxs_d[c]) begin
          rxs_d[c] = 1'b0;
          do_tx    = txp_d[c];
        end else begin
          txs_d[c] = 1'b0;
        end
      end
      if (rx_evt[c]) do_rx = 1'b1;
      if (tx_evt[c]) do_tx = 1'b1;
      if (do_rx) begin
        rxp_d[c] = 1'b1;
        rxs_d[c] = 1'b1;
        pend_d   = pend_d | rx_bit(c);
        vec_d    = rx_code(c, stat_hi);
      end
      if (do_tx) begin
        txp_d[c] = 1'b1;
        if (!rxs_d[c]) begin
          txs_d[c] = 1'b1;
          if (cfg[c][1]) pend_d = pend_d | tx_bit(c);
          vec_d = tx_code(c, stat_hi);
        end
      end
      if (brk_evt[c]) brk_d[c] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxp_q <= '0; txp_q <= '0; rxs_q <= '0; txs_q <= '0; brk_q <= '0;
      pend_q <= 8'h00; vec_q <= 8'h00; irq_q <= 1'b0;
    end else begin
      rxp_q <= rxp_d; txp_q <= txp_d; rxs_q <= rxs_d; txs_q <= txs_d; brk_q <= brk_d;
      pend_q <= pend_d; vec_q <= vec_d;
      irq_q  <= |req;
    end
  end

  assign irq  = irq_q;
  assign pend = pend_q;
  assign vec  = vec_q;

  p_rx_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rxp_q[0] && (^wr1_a[4:3])) |=> irq);

  p_brk_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_q[1] && brk_en[1]) |=> irq);

  p_vec_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_q inside {8'h00, 8'h04, 8'h06, 8'h08, 8'h0C, 8'h10, 8'h20, 8'h30, 8'h60});

  p_rx_masks_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rxs_q[0] && tx_evt[0] && !rx_evt[0] && !rd_data[0] && !cmd_rst_tx[0] && !cmd_rst_ius[0]
     && !rx_evt[1] && !tx_evt[1] && !rd_data[1] && !cmd_rst_tx[1] && !cmd_rst_ius[1])
    |=> $stable(vec_q) && $stable(pend_q));

  p_rst_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rst_tx[0] && !rd_data[0] && !wr_data[0] && !tx_evt[0]) |=> !pend_q[4] && !txp_q[0]);

  p_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[0] && !rx_evt[0]) |=> !rxp_q[0] && !pend_q[5]);

  p_txie_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr1_b[1] && !pend_q[1]) |=> !pend_q[1]);

  p_ext_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q[5]) |-> !pend_q[3] && !pend_q[0]);

endmodule

// File: tb/test_sio_irq_vector.sv
module test_sio_irq_vector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] wr1_a = 8'h00, wr1_b = 8'h00;
  logic [1:0] brk_en = 2'b00;
  logic stat_hi = 1'b0;
  logic [1:0] rx_evt = '0, tx_evt = '0, brk_evt = '0, rd_data = '0, wr_data = '0;
  logic [1:0] cmd_rst_tx = '0, cmd_rst_ius = '0;
  logic irq;
  logic [7:0] pend, vec;

  int total = 0, bad = 0;
  bit done = 0;

  logic [1:0] m_rxp, m_txp, m_rxs, m_txs, m_brk;
  logic [7:0] m_pend, m_vec;

  always #4 clk = ~clk;

  sio_irq_vector i_sio_irq_vector (
    .clk(clk), .rst_n(rst_n), .wr1_a(wr1_a), .wr1_b(wr1_b), .brk_en(brk_en),
    .stat_hi(stat_hi), .rx_evt(rx_evt), .tx_evt(tx_evt), .brk_evt(brk_evt),
    .rd_data(rd_data), .wr_data(wr_data), .cmd_rst_tx(cmd_rst_tx),
    .cmd_rst_ius(cmd_rst_ius), .irq(irq), .pend(pend), .vec(vec));

  function automatic logic [7:0] cfg_of(int c);
    return (c == 0) ? wr1_a : wr1_b;
  endfunction

  // arithmetic encodings: A is channel 0
  function automatic logic [7:0] e_rxc(int c);
    return stat_hi ? 8'(8'h20 + ((c == 0) ? 8'h10 : 8'h00)) : 8'(8'h04 + ((c == 0) ? 8'h08 : 8'h00));
  endfunction
  function automatic logic [7:0] e_txc(int c);
    return (c == 0) ? (stat_hi ? 8'h10 : 8'h08) : 8'h00;
  endfunction
  function automatic logic [7:0] e_none();
    return stat_hi ? 8'h60 : 8'h06;
  endfunction
  function automatic logic [7:0] e_rxb(int c);
    return 8'(8'h04 << ((c == 0) ? 3 : 0));
  endfunction
  function automatic logic [7:0] e_txb(int c);
    return 8'(8'h02 << ((c == 0) ? 3 : 0));
  endfunction

  function automatic logic m_req();
    logic r = 1'b0;
    for (int c = 0; c < 2; c++) begin
      logic [7:0] w = cfg_of(c);
      if (w[1] && m_txp[c]) r = 1'b1;
      if ((w[4:3] == 2'b01 || w[4:3] == 2'b10) && m_rxp[c]) r = 1'b1;
      if (brk_en[c] && m_brk[c]) r = 1'b1;
    end
    return r;
  endfunction

  task automatic m_set_rx(int c);
    m_rxp[c] = 1; m_rxs[c] = 1; m_pend |= e_rxb(c); m_vec = e_rxc(c);
  endtask

  task automatic m_set_tx(int c);
    logic [7:0] w = cfg_of(c);
    m_txp[c] = 1;
    if (!m_rxs[c]) begin
      m_txs[c] = 1;
      if (w[1]) m_pend |= e_txb(c);
      m_vec = e_txc(c);
    end
  endtask

  // event codes: 0 none,1 read,2 write,3 tx reset,4 ius reset,5 rx,6 tx,7 break
  task automatic m_apply(int c, int ev);
    case (ev)
      1: begin m_rxp[c] = 0; m_rxs[c] = 0; m_vec = e_none(); m_pend &= ~e_rxb(c);
               if (m_txp[c]) m_set_tx(c); end
      2: m_txp[c] = 0;
      3: begin m_txp[c] = 0; m_txs[c] = 0; m_vec = e_none(); m_pend &= ~e_txb(c);
               if (m_rxp[c]) m_set_rx(c); end
      4: begin if (m_rxs[c]) begin m_rxs[c] = 0; if (m_txp[c]) m_set_tx(c); end
               else m_txs[c] = 0; end
      5: m_set_rx(c);
      6: m_set_tx(c);
      7: m_brk[c] = 1;
      default: ;
    endcase
  endtask

  task automatic drive(int c, int ev);
    case (ev)
      1: rd_data[c] = 1;
      2: wr_data[c] = 1;
      3: cmd_rst_tx[c] = 1;
      4: cmd_rst_ius[c] = 1;
      5: rx_evt[c] = 1;
      6: tx_evt[c] = 1;
      7: brk_evt[c] = 1;
      default: ;
    endcase
  endtask

  task automatic chk(string tag, string what, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%02h exp=%02h t=%0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic step(string tag, int ev_a, int ev_b);
    logic exp_irq;
    exp_irq = m_req();
    drive(0, ev_a); drive(1, ev_b);
    m_apply(0, ev_a); m_apply(1, ev_b);
    @(posedge clk); @(negedge clk);
    {rx_evt, tx_evt, brk_evt, rd_data, wr_data, cmd_rst_tx, cmd_rst_ius} = '0;
    chk(tag, "pend", pend, m_pend);
    chk(tag, "vec", vec, m_vec);
    chk(tag, "irq", {7'd0, irq}, {7'd0, exp_irq});
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_rxp = 0; m_txp = 0; m_rxs = 0; m_txs = 0; m_brk = 0; m_pend = 0; m_vec = 0;
    chk("R13", "pend", pend, 8'h00);
    chk("R13", "vec", vec, 8'h00);
    chk("R13", "irq", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    @(negedge clk);
    // directed, status low, everything enabled
    wr1_a = 8'h12; wr1_b = 8'h12; brk_en = 2'b00; stat_hi = 0;
    do_reset();
    step("R4", 5, 0);                 // rx A -> 0x0C, pend 0x20
    chk("R4", "vec code", vec, 8'h0C);
    step("R5", 6, 0);                 // tx A masked by rx service
    chk("R5", "vec held", vec, 8'h0C);
    step("R1", 0, 0);
    chk("R1", "irq", {7'd0, irq}, 8'h01);
    step("R6", 4, 0);                 // release rx service -> tx A vector
    chk("R6", "vec tx A", vec, 8'h08);
    step("R8", 1, 0);                 // read: rx cleared, tx re-raised
    chk("R8", "pend", pend, 8'h10);
    step("R7", 3, 0);                 // tx reset -> none
    chk("R7", "vec none", vec, 8'h06);
    step("R9", 6, 0);
    step("R9", 2, 0);                 // write drops tx pending
    step("R9", 0, 0);
    chk("R9", "irq low", {7'd0, irq}, 8'h00);
    step("R9", 6, 0);
    step("R9", 0, 0);
    chk("R9", "irq back", {7'd0, irq}, 8'h01);
    step("R12", 5, 5);                // both channels: B code wins
    chk("R12", "vec rx B", vec, 8'h04);
    step("R2", 0, 6);
    chk("R2", "pend bits", pend, 8'h34);
    // tx interrupts disabled on B
    wr1_b = 8'h08;
    do_reset();
    step("R10", 0, 6);
    chk("R10", "no tx bit", pend, 8'h00);
    // break with status high
    wr1_a = 8'h00; wr1_b = 8'h00; brk_en = 2'b10; stat_hi = 1;
    do_reset();
    step("R11", 0, 7);
    step("R11", 0, 1);
    step("R11", 0, 0);
    chk("R11", "sticky irq", {7'd0, irq}, 8'h01);
    step("R3", 5, 0);
    chk("R3", "hi rx A", vec, 8'h30);

    // sweep over configurations
    for (int cf = 0; cf < 64; cf++) begin
      logic [1:0] rxm;
      rxm = 2'(cf & 3);
      stat_hi = cf[2];
      wr1_a = {3'b000, rxm, 1'b0, cf[3], 1'b0};
      wr1_b = {3'b000, 2'(rxm + 2'd1), 1'b0, cf[4], 1'b0};
      brk_en = {cf[5], cf[5]};
      do_reset();
      for (int s = 0; s < 150; s++) begin
        int ea, eb;
        ea = $urandom_range(0, 6);
        eb = $urandom_range(0, 6);
        if ($urandom_range(0, 99) == 0) ea = 7;
        if ($urandom_range(0, 2) == 0) eb = 0;
        step((s % 3 == 0) ? "R1" : ((s % 3 == 1) ? "R2" : "R3"), ea, eb);
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule